// File: doc/BRIEF.md
# Two-Cycle Complex Mixer with First Integrator

This block mixes a complex baseband stream with a local oscillator and feeds the result straight into the first integrator of a decimating CIC filter. Each complex sample reaches it as two real words on successive accepted clocks. A phase flag marks the in-phase word, and the quadrature word follows it. The block has only two real multipliers, one per output path, and uses each of them twice for every complex sample. The two cross terms of the complex product are never summed in an adder stage of their own. They are combined in the integrator registers themselves, so the full complex product is in the integrators only after the quadrature word.

The oscillator cosine and sine are taken from the ports on the in-phase clock and held for the quadrature clock. Both halves of the product therefore use the same oscillator phase. A one-clock completion strobe tells the next CIC stage when the two integrator sums hold a finished complex sample. Because every complex sample needs two clocks, the stage that follows must decimate by exactly two.

Top module: `cplx_mix_integ`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted word, both integrator outputs read zero and the completion strobe is low. Reset is asynchronous and active-low, and it is released through two synchronizer flops.
- R2: A word with `samp_vld`=1 and `samp_phase`=1 is an in-phase word. One clock later, `integ_i` has grown by data×`lo_cos` and `integ_q` has grown by data×`lo_sin`, using the oscillator values present on that clock.
- R3: A word with `samp_vld`=1 and `samp_phase`=0 that follows an in-phase word is a quadrature word. It subtracts data×sine from `integ_i` and adds data×cosine to `integ_q`. The cosine and sine are the values held from the in-phase clock, and the oscillator ports on the quadrature clock have no effect.
- R4: `pair_done` is high for exactly one clock, in the cycle right after each accepted quadrature word, and it is never high in two consecutive cycles.
- R5: A quadrature word with no pending in-phase word is ignored: neither integrator changes and `pair_done` stays low.
- R6: On a clock with `samp_vld`=0, both integrators hold their values. Idle clocks between an in-phase word and its quadrature word do not cancel the pending pair.
- R7: The integrators are DATA_W+LO_W+GROWTH bits wide (36 by default) and wrap in two's complement with no saturation.
- R8: A second in-phase word before any quadrature word is added as well and replaces the held oscillator values. The quadrature word that follows uses the newer values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_vld | input | 1 | Sample word present this clock |
| samp_phase | input | 1 | 1 = in-phase word, 0 = quadrature word |
| samp_data | input | DATA_W | Signed sample word |
| lo_cos | input | LO_W | Signed oscillator cosine |
| lo_sin | input | LO_W | Signed oscillator sine |
| integ_i | output | ACC_W | I-path first integrator state |
| integ_q | output | ACC_W | Q-path first integrator state |
| pair_done | output | 1 | One-clock strobe: complex sample complete |

## Verification
The bound checker checks the per-clock arithmetic on every cycle. This covers the in-phase additions, the quadrature subtraction and addition against the held oscillator values, holding on idle clocks, the rejection of an orphan quadrature word, and the shape of the completion strobe. The held oscillator value cannot change between the two halves, which is what makes the accumulated I·cos − Q·sin and I·sin + Q·cos sums correct. Only the bench's scenarios show this, by changing the oscillator ports on the quadrature clock, and the same holds for the long-run wrap-around of the integrators. The repeated in-phase case and a reset in the middle of a run are also shown only by the bench's scenarios.

// File: rtl/mix_pkg.sv
package mix_pkg;
  typedef enum logic {
    PH_QUAD = 1'b0,
    PH_INPH = 1'b1
  } phase_e;

  localparam int NUM_PATHS = 2;
  localparam int PATH_I    = 0;
  localparam int PATH_Q    = 1;
endpackage

// File: rtl/mix_lo_hold.sv
module mix_lo_hold #(
  parameter int LO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inph_fire,
  input  logic            quad_fire,
  input  logic [LO_W-1:0] cos_in,
  input  logic [LO_W-1:0] sin_in,
  output logic [LO_W-1:0] cos_hold,
  output logic [LO_W-1:0] sin_hold,
  output logic            armed
);
  logic [LO_W-1:0] cos_nxt, sin_nxt;
  logic            armed_nxt;

  always_comb begin
    cos_nxt   = cos_hold;
    sin_nxt   = sin_hold;
    armed_nxt = armed;
    if (inph_fire) begin
      cos_nxt   = cos_in;
      sin_nxt   = sin_in;
      armed_nxt = 1'b1;
    end else if (quad_fire) begin
      armed_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cos_hold <= '0;
      sin_hold <= '0;
      armed    <= 1'b0;
    end else begin
      cos_hold <= cos_nxt;
      sin_hold <= sin_nxt;
      armed    <= armed_nxt;
    end
  end
endmodule

// File: rtl/mix_mult.sv
module mix_mult #(
  parameter int A_W = 16,
  parameter int B_W = 16,
  localparam int P_W = A_W + B_W
) (
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [P_W-1:0] p
);
  logic signed [P_W-1:0] a_ext, b_ext;

  always_comb begin
    a_ext = $signed({{B_W{a[A_W-1]}}, a});
    b_ext = $signed({{A_W{b[B_W-1]}}, b});
    p     = a_ext * b_ext;
  end
endmodule

// File: rtl/mix_integ.sv
module mix_integ #(
  parameter int P_W   = 32,
  parameter int ACC_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sub,
  input  logic [P_W-1:0]   prod,
  output logic [ACC_W-1:0] acc
);
  localparam int EXT_W = ACC_W - P_W;

  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0] acc_nxt;

  always_comb begin
    prod_ext = {{EXT_W{prod[P_W-1]}}, prod};
    acc_nxt  = acc;
    if (en) begin
      acc_nxt = sub ? (acc - prod_ext) : (acc + prod_ext);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_nxt;
  end
endmodule

// File: rtl/cplx_mix_integ.sv
module cplx_mix_integ #(
  parameter int DATA_W = 16,
  parameter int LO_W   = 16,
  parameter int GROWTH = 4,
  localparam int P_W   = DATA_W + LO_W,
  localparam int ACC_W = P_W + GROWTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_vld,
  input  logic              samp_phase,
  input  logic [DATA_W-1:0] samp_data,
  input  logic [LO_W-1:0]   lo_cos,
  input  logic [LO_W-1:0]   lo_sin,
  output logic [ACC_W-1:0]  integ_i,
  output logic [ACC_W-1:0]  integ_q,
  output logic              pair_done
);
  import mix_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  phase_e          ph;
  logic            inph_fire, quad_fire;
  logic            armed;
  logic [LO_W-1:0] cos_hold, sin_hold;

  always_comb begin
    ph        = phase_e'(samp_phase);
    inph_fire = samp_vld && (ph == PH_INPH);
    quad_fire = samp_vld && (ph == PH_QUAD) && armed;
  end

  mix_lo_hold #(.LO_W(LO_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .inph_fire(inph_fire),
    .quad_fire(quad_fire),
    .cos_in   (lo_cos),
    .sin_in   (lo_sin),
    .cos_hold (cos_hold),
    .sin_hold (sin_hold),
    .armed    (armed)
  );

  // per-path coefficient choice: I path cos then sin, Q path sin then cos
  logic [LO_W-1:0]  coef [NUM_PATHS];
  logic             sub  [NUM_PATHS];
  logic [P_W-1:0]   prod [NUM_PATHS];
  logic [ACC_W-1:0] acc  [NUM_PATHS];

  always_comb begin
    coef[PATH_I] = inph_fire ? lo_cos : sin_hold;
    coef[PATH_Q] = inph_fire ? lo_sin : cos_hold;
    sub[PATH_I]  = quad_fire;
    sub[PATH_Q]  = 1'b0;
  end

  for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
    mix_mult #(.A_W(DATA_W), .B_W(LO_W)) u_mult (
      .a(samp_data),
      .b(coef[g]),
      .p(prod[g])
    );
    mix_integ #(.P_W(P_W), .ACC_W(ACC_W)) u_integ (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .en   (inph_fire || quad_fire),
      .sub  (sub[g]),
      .prod (prod[g]),
      .acc  (acc[g])
    );
  end

  logic done_nxt;
  always_comb done_nxt = quad_fire;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pair_done <= 1'b0;
    else             pair_done <= done_nxt;
  end

  assign integ_i = acc[PATH_I];
  assign integ_q = acc[PATH_Q];
endmodule

module mix_chk #(
  parameter int DATA_W = 16,
  parameter int LO_W   = 16,
  parameter int ACC_W  = 36
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              samp_vld,
  input logic              samp_phase,
  input logic [DATA_W-1:0] samp_data,
  input logic [LO_W-1:0]   lo_cos,
  input logic [LO_W-1:0]   lo_sin,
  input logic              armed,
  input logic [LO_W-1:0]   cos_hold,
  input logic [LO_W-1:0]   sin_hold,
  input logic [ACC_W-1:0]  integ_i,
  input logic [ACC_W-1:0]  integ_q,
  input logic              pair_done
);
  function automatic logic [ACC_W-1:0] pr(logic [DATA_W-1:0] d, logic [LO_W-1:0] c);
    logic signed [ACC_W-1:0] de, ce;
    de = $signed({{(ACC_W-DATA_W){d[DATA_W-1]}}, d});
    ce = $signed({{(ACC_W-LO_W){c[LO_W-1]}}, c});
    return de * ce;
  endfunction

  assert_inph_i_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (samp_vld && samp_phase) |=>
      integ_i == $past(integ_i) + pr($past(samp_data), $past(lo_cos)));

  assert_inph_q_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (samp_vld && samp_phase) |=>
      integ_q == $past(integ_q) + pr($past(samp_data), $past(lo_sin)));

  assert_quad_i_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (samp_vld && !samp_phase && armed) |=>
      integ_i == $past(integ_i) - pr($past(samp_data), $past(sin_hold)));

  assert_quad_q_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (samp_vld && !samp_phase && armed) |=>
      integ_q == $past(integ_q) + pr($past(samp_data), $past(cos_hold)));

  assert_done_after_quad_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (samp_vld && !samp_phase && armed) |=> pair_done);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    pair_done |=> !pair_done);

  assert_orphan_quad_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (samp_vld && !samp_phase && !armed) |=>
      (!pair_done && $stable(integ_i) && $stable(integ_q)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    !samp_vld |=> ($stable(integ_i) && $stable(integ_q) && !pair_done));
endmodule

bind cplx_mix_integ mix_chk #(.DATA_W(DATA_W), .LO_W(LO_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .samp_vld  (samp_vld),
  .samp_phase(samp_phase),
  .samp_data (samp_data),
  .lo_cos    (lo_cos),
  .lo_sin    (lo_sin),
  .armed     (armed),
  .cos_hold  (cos_hold),
  .sin_hold  (sin_hold),
  .integ_i   (integ_i),
  .integ_q   (integ_q),
  .pair_done (pair_done)
);

// File: tb/sim_cplx_mix_integ.sv
module sim_cplx_mix_integ;
  localparam int DW = 16;
  localparam int LW = 16;
  localparam int GW = 4;
  localparam int AW = DW + LW + GW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          vld, ph;
  logic [DW-1:0] dat;
  logic [LW-1:0] cs, sn;
  logic [AW-1:0] oi, oq;
  logic          done;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  cplx_mix_integ #(.DATA_W(DW), .LO_W(LW), .GROWTH(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .samp_vld(vld), .samp_phase(ph),
    .samp_data(dat), .lo_cos(cs), .lo_sin(sn),
    .integ_i(oi), .integ_q(oq), .pair_done(done)
  );

  // reference model state
  logic [AW-1:0] m_i, m_q;
  logic [LW-1:0] h_cos, h_sin;
  bit            m_armed;
  logic [2*AW-1:0] exp_q[$];

  function automatic logic [AW-1:0] mul(logic [DW-1:0] d, logic [LW-1:0] c);
    longint a, b;
    a = longint'($signed(d));
    b = longint'($signed(c));
    return AW'(a * b);
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic model_clear();
    m_i = '0; m_q = '0; h_cos = '0; h_sin = '0; m_armed = 0;
    exp_q.delete();
  endtask

  task automatic idle(int n);
    vld = 1'b0;
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic send_inph(logic [DW-1:0] d, logic [LW-1:0] c, logic [LW-1:0] s);
    m_i = m_i + mul(d, c);
    m_q = m_q + mul(d, s);
    h_cos = c; h_sin = s; m_armed = 1;
    vld = 1'b1; ph = 1'b1; dat = d; cs = c; sn = s;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic send_quad(logic [DW-1:0] d, logic [LW-1:0] c, logic [LW-1:0] s);
    if (m_armed) begin
      m_i = m_i - mul(d, h_sin);
      m_q = m_q + mul(d, h_cos);
      m_armed = 0;
      exp_q.push_back({m_i, m_q});
    end
    vld = 1'b1; ph = 1'b0; dat = d; cs = c; sn = s;
    @(negedge clk);
    vld = 1'b0;
  endtask

  // monitor: scoreboard pop on each completion strobe
  bit prev_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) begin
        total++; bad++;
        $display("FAIL R4 strobe high two cycles act=1 exp=0");
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R4/R5 unexpected strobe act=1 exp=0");
        end else begin
          logic [2*AW-1:0] e;
          e = exp_q.pop_front();
          chk("R3 pair I sum", oi, e[2*AW-1:AW]);
          chk("R3 pair Q sum", oq, e[AW-1:0]);
        end
      end
    end
    prev_done = done;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] si, sq;
    rst_n = 1'b0; vld = 1'b0; ph = 1'b0; dat = '0; cs = '0; sn = '0;
    model_clear();
    repeat (4) @(negedge clk);
    chk("R1 reset integ_i", oi, '0);
    chk("R1 reset integ_q", oq, '0);
    chk("R1 reset strobe", AW'(done), '0);
    rst_n = 1'b1;
    idle(4);
    chk("R1 after release integ_i", oi, '0);

    // R2: in-phase contributions visible one clock later
    send_inph(16'sd100, 16'sd3000, -16'sd2000);
    chk("R2 inph I", oi, m_i);
    chk("R2 inph Q", oq, m_q);
    // R3: oscillator ports changed on quad clock must not matter
    send_quad(-16'sd50, 16'sd7, 16'sd9);
    idle(1);

    // R6: gap between halves keeps pair pending
    send_inph(16'sd1234, -16'sd4321, 16'sd555);
    si = oi; sq = oq;
    idle(3);
    chk("R6 idle hold I", oi, si);
    chk("R6 idle hold Q", oq, sq);
    send_quad(16'sd777, 16'sd0, 16'sd0);
    idle(1);

    // R5: orphan quadrature word ignored
    si = oi; sq = oq;
    send_quad(16'sd3000, 16'sd1000, 16'sd1000);
    chk("R5 orphan I", oi, si);
    chk("R5 orphan Q", oq, sq);
    chk("R5 orphan strobe", AW'(done), '0);

    // R8: repeated in-phase adds and replaces held oscillator
    send_inph(16'sd40, 16'sd100, 16'sd200);
    send_inph(-16'sd60, 16'sd300, -16'sd400);
    chk("R8 second inph I", oi, m_i);
    send_quad(16'sd25, 16'sd1, 16'sd1);
    idle(1);

    // R3/R4: random back-to-back pairs
    for (int n = 0; n < 30; n++) begin
      send_inph(DW'($urandom), LW'($urandom), LW'($urandom));
      send_quad(DW'($urandom), LW'($urandom), LW'($urandom));
    end
    idle(2);
    chk("R3 random run final I", oi, m_i);
    chk("R3 random run final Q", oq, m_q);

    // R7: wrap-around with largest positive products
    for (int n = 0; n < 40; n++) begin
      send_inph(16'h8000, 16'h8000, 16'h8000);
      send_quad(16'h8000, 16'h8000, 16'h7fff);
    end
    idle(2);
    chk("R7 wrap I", oi, m_i);
    chk("R7 wrap Q", oq, m_q);

    // R1: reset in the middle of a run
    send_inph(16'sd5, 16'sd5, 16'sd5);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset I", oi, '0);
    chk("R1 mid reset Q", oq, '0);
    model_clear();
    rst_n = 1'b1;
    idle(4);
    send_quad(16'sd99, 16'sd9, 16'sd9);
    chk("R5 quad after reset ignored", oi, '0);
    idle(2);

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R4 missing strobes act=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule